// File: doc/BRIEF.md
# Prioritised Interrupt Router Core

This block collects a set of level-sensitive global interrupt sources and delivers them to several targets, where a target (context) is one privilege mode on one hart. Each hart owns two neighbouring context indices: the even one is its machine mode and the odd one its supervisor mode. A context index is therefore not a hart number. Software programs a priority for each source, an enable mask for each context and a threshold for each context, all through a single-cycle register port.

Each context has its own interrupt output. A handler reads the context's claim register to learn which source to serve. The read also holds that source off from further delivery. The handler then writes the same number back to finish the interrupt. Source numbers start at 1, and the value 0 always means "nothing to serve".

Top module: `irq_router_core`

## Requirements
- R1: After reset every priority, enable bit and threshold is 0, no source is pending, every `ctx_irq` bit is low and every claim read returns 0.
- R2: The priority of source ID lives at byte address 4*ID and is 3 bits wide. Bits above bit 2 read as 0. The word at address 0, which belongs to ID 0, reads 0 and ignores writes.
- R3: The enable bit of source ID for context c is bit (ID mod 32) of the word at 0x2000 + 0x80*c + 4*(ID div 32). Bit 0 of word 0 stands for ID 0; it always reads 0 and cannot be set.
- R4: The 3-bit threshold of context c is at 0x200000 + 0x1000*c. The claim/complete register of context c is at 0x200000 + 0x1000*c + 4.
- R5: `ctx_irq[c]` is a registered output. It is high only when some source is pending, is enabled for c, and has a priority strictly greater than c's threshold. It follows such a change one clock later.
- R6: A source whose priority is 0 never raises any `ctx_irq` bit and is never returned by a claim read.
- R7: A claim read returns the ID of the eligible source with the highest priority. When priorities tie, the smallest ID wins.
- R8: A claim read clears that source's pending state and marks it in service. While a source is in service it neither raises an interrupt nor is returned again, even while its input stays high.
- R9: Writing the in-service ID to the claim/complete register of a context whose enable bit for that source is set ends the service. If the input is still high, the source becomes pending again.
- R10: A claim read with no eligible source returns 0 and changes no state. A complete write is ignored when its ID is not in service, or when the source's enable bit is clear for that context.
- R11: Contexts are independent. A source raises and can be claimed only in the contexts that enable it and whose threshold it exceeds.
- R12: Reads of addresses that map to no register return 0. This covers the gaps between regions, enable space beyond the last context, and context-block offsets other than 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC | Level requests; bit i is source ID i+1 |
| reg_sel | input | 1 | Register access strobe for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| ctx_irq | output | NCTX | Registered interrupt line per context |

## Verification
The arbitration is driven with three kinds of pattern.

- **Single source against its threshold.** One source is set equal to the threshold and then one step above it. This separates the strict greater-than rule from greater-or-equal.
- **Three sources, two of them tied.** Three simultaneous requests are drained by claims one after another. This shows that priority decides before ID, and that the lower ID wins a tie.
- **Claim and complete sequences.** The input is held high through a claim, through completes that must be ignored, and through the proper complete. This separates correct hold-off and re-arm from a gateway that re-triggers or releases too early.

Priority-zero sources and a source enabled in only one context check that eligibility is decided per context.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_PRIO,
    RGN_ENABLE,
    RGN_CTX
  } rgn_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic inflight_o
);
  logic pend_q, pend_d, infl_q, infl_d;

  always_comb begin
    pend_d = pend_q;
    infl_d = infl_q;
    if (claim_i) begin
      pend_d = 1'b0;
      infl_d = 1'b1;
    end else if (level_i && !pend_q && !infl_q) begin
      pend_d = 1'b1;
    end
    if (complete_i && infl_q) infl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      infl_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      infl_q <= infl_d;
    end
  end

  assign pending_o  = pend_q;
  assign inflight_o = infl_q;

  a_r8_claim_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> pend_q);
  a_r8_claim_takes_service: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (infl_q && !pend_q));
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_q && !complete_i) |=> !pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]           thresh_i,
  output logic [ID_W-1:0]             id_o,
  output logic                        eligible_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (prio_i[i] > best_p)) begin
        best_p  = prio_i[i];
        best_id = ID_W'(i + 1);
      end
    end
    eligible_o = (best_p > thresh_i);
    id_o       = eligible_o ? best_id : '0;
  end
endmodule

// File: rtl/irq_router_core.sv
module irq_router_core #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 4,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_level,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCTX-1:0]   ctx_irq
);
  import irq_router_pkg::*;

  localparam int ID_W   = $clog2(NSRC + 1);
  localparam int NWORDS = (NSRC + 32) / 32;
  localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] ENA_BASE = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] ENA_END  = ADDR_W'(32'h2000 + NCTX * 32'h80);
  localparam logic [ADDR_W-1:0] CTX_BASE = ADDR_W'(32'h200000);
  localparam logic [ADDR_W-1:0] CTX_END  = ADDR_W'(32'h200000 + NCTX * 32'h1000);

  // register state
  logic [NSRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NCTX-1:0][NSRC-1:0]   ena_q, ena_d;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q, thr_d;
  logic [NCTX-1:0]             irq_q;

  // decode
  rgn_e             rgn;
  logic [9:0]       prio_idx;
  logic             prio_hit;
  logic [CTX_W-1:0] ena_ctx, blk_ctx;
  logic [4:0]       ena_word;
  logic             thr_hit, clm_hit;

  always_comb begin
    if (reg_addr < PRIO_END)                             rgn = RGN_PRIO;
    else if (reg_addr >= ENA_BASE && reg_addr < ENA_END) rgn = RGN_ENABLE;
    else if (reg_addr >= CTX_BASE && reg_addr < CTX_END) rgn = RGN_CTX;
    else                                                 rgn = RGN_NONE;
  end

  assign prio_idx = reg_addr[11:2];
  assign prio_hit = (rgn == RGN_PRIO) && (prio_idx != 10'd0) && (int'(prio_idx) <= NSRC);
  assign ena_ctx  = reg_addr[CTX_W+6:7];
  assign ena_word = reg_addr[6:2];
  assign blk_ctx  = reg_addr[CTX_W+11:12];
  assign thr_hit  = (rgn == RGN_CTX) && (reg_addr[11:0] == 12'h000);
  assign clm_hit  = (rgn == RGN_CTX) && (reg_addr[11:0] == 12'h004);

  // gateways and per-context arbitration
  logic [NSRC-1:0]           pending, inflight, claim_vec, complete_vec;
  logic [NCTX-1:0][ID_W-1:0] win_id;
  logic [NCTX-1:0]           elig;

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    irq_gateway u_gw (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (src_level[j]),
      .claim_i   (claim_vec[j]),
      .complete_i(complete_vec[j]),
      .pending_o (pending[j]),
      .inflight_o(inflight[j])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand_i    (pending & ena_q[c]),
      .prio_i    (prio_q),
      .thresh_i  (thr_q[c]),
      .id_o      (win_id[c]),
      .eligible_o(elig[c])
    );
  end

  logic claim_go, complete_go;
  assign claim_go    = reg_sel && !reg_wr && clm_hit && elig[blk_ctx];
  assign complete_go = reg_sel &&  reg_wr && clm_hit;

  always_comb begin
    for (int j = 0; j < NSRC; j++) begin
      claim_vec[j]    = claim_go && (win_id[blk_ctx] == ID_W'(j + 1));
      complete_vec[j] = complete_go && (reg_wdata == 32'(j + 1))
                        && ena_q[blk_ctx][j] && inflight[j];
    end
  end

  // register writes: next state
  always_comb begin
    prio_d = prio_q;
    ena_d  = ena_q;
    thr_d  = thr_q;
    if (reg_sel && reg_wr) begin
      if (prio_hit) prio_d[prio_idx - 10'd1] = reg_wdata[PRIO_W-1:0];
      if (thr_hit)  thr_d[blk_ctx] = reg_wdata[PRIO_W-1:0];
      if (rgn == RGN_ENABLE) begin
        for (int j = 0; j < NSRC; j++) begin
          if ((j + 1) / 32 == int'(ena_word)) ena_d[ena_ctx][j] = reg_wdata[(j + 1) % 32];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      ena_q  <= '0;
      thr_q  <= '0;
      irq_q  <= '0;
    end else begin
      prio_q <= prio_d;
      ena_q  <= ena_d;
      thr_q  <= thr_d;
      irq_q  <= elig;
    end
  end

  // read data, same cycle
  always_comb begin
    reg_rdata = '0;
    if (prio_hit) begin
      reg_rdata = 32'(prio_q[prio_idx - 10'd1]);
    end else if (rgn == RGN_ENABLE && int'(ena_word) < NWORDS) begin
      for (int j = 0; j < NSRC; j++) begin
        if ((j + 1) / 32 == int'(ena_word)) reg_rdata[(j + 1) % 32] = ena_q[ena_ctx][j];
      end
    end else if (thr_hit) begin
      reg_rdata = 32'(thr_q[blk_ctx]);
    end else if (clm_hit) begin
      reg_rdata = 32'(win_id[blk_ctx]);
    end
  end

  assign ctx_irq = irq_q;

  // R8: one port, so at most one source is claimed per cycle
  a_r8_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  for (genvar j = 0; j < NSRC; j++) begin : g_chk
    a_r6_claim_nonzero_prio: assert property (@(posedge clk) disable iff (!rst_n)
      claim_vec[j] |-> (prio_q[j] != '0));
    a_r10_complete_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      complete_vec[j] |=> !inflight[j]);
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_irqchk
    a_r5_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_irq[c] |-> $past(|(pending & ena_q[c])));
  end
endmodule

// File: tb/irq_router_core_test.sv
module irq_router_core_test;
  localparam int NSRC = 31;
  localparam int NCTX = 4;

  logic              clk;
  logic              rst_n;
  logic [NSRC-1:0]   src_level;
  logic              reg_sel, reg_wr;
  logic [21:0]       reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [NCTX-1:0]   ctx_irq;

  int checks = 0;
  int errors = 0;

  irq_router_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(22)) uut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctx_irq(ctx_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [21:0] a_prio(int id); return 22'(4 * id); endfunction
  function automatic logic [21:0] a_ena(int c);   return 22'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [21:0] a_thr(int c);   return 22'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [21:0] a_clm(int c);   return 22'(32'h200004 + 32'h1000 * c); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #5 d = reg_rdata;
    @(posedge clk); #1;
    reg_sel = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R1 irq after reset", 32'(ctx_irq), 32'h0);
    rd(a_prio(3), d); chk("R1 priority after reset", d, 0);
    rd(a_ena(1), d);  chk("R1 enables after reset", d, 0);
    rd(a_thr(2), d);  chk("R1 threshold after reset", d, 0);
    rd(a_clm(0), d);  chk("R1 claim after reset", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(a_prio(3), 32'hFFFF_FFFD); rd(a_prio(3), d); chk("R2 priority 3-bit", d, 5);
    wr(a_prio(0), 32'h7);         rd(a_prio(0), d); chk("R2 id0 priority", d, 0);
    wr(a_ena(0), 32'hFFFF_FFFF);  rd(a_ena(0), d);  chk("R3 enable bit0 fixed", d, 32'hFFFF_FFFE);
    rd(a_ena(2), d);              chk("R3 other context untouched", d, 0);
    wr(a_thr(1), 32'hA);          rd(a_thr(1), d);  chk("R4 threshold 3-bit", d, 2);
    rd(22'h1800, d);              chk("R12 gap read", d, 0);
    rd(22'h2200, d);              chk("R12 enable beyond last context", d, 0);
    rd(22'h200008, d);            chk("R12 context offset 8", d, 0);
    wr(a_ena(0), 0); wr(a_thr(1), 0); wr(a_prio(3), 0);
  endtask

  task automatic t_threshold_and_claim;
    logic [31:0] d;
    wr(a_prio(5), 3);
    wr(a_ena(0), 32'h1 << 5);
    wr(a_thr(0), 3);
    src_level[4] = 1'b1;
    idle(3);
    chk("R5 priority equal to threshold", 32'(ctx_irq), 0);
    rd(a_clm(0), d); chk("R10 claim with none eligible", d, 0);
    wr(a_thr(0), 2);
    idle(2);
    chk("R5 priority above threshold", 32'(ctx_irq[0]), 1);
    chk("R11 context 1 not enabled", 32'(ctx_irq[1]), 0);
    rd(a_clm(0), d); chk("R7 claim returns source", d, 5);
    idle(2);
    chk("R8 held off after claim", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d); chk("R8 no second claim", d, 0);
    wr(a_clm(0), 6);
    wr(a_ena(0), 0);
    wr(a_clm(0), 5);
    wr(a_ena(0), 32'h1 << 5);
    idle(3);
    chk("R10 bad completes ignored", 32'(ctx_irq[0]), 0);
    wr(a_clm(0), 5);
    idle(3);
    chk("R9 re-pends after complete", 32'(ctx_irq[0]), 1);
    rd(a_clm(0), d); chk("R9 claim after re-pend", d, 5);
    src_level[4] = 1'b0;
    wr(a_clm(0), 5);
    idle(3);
    chk("R9 low input stays idle", 32'(ctx_irq[0]), 0);
    rd(a_clm(0), d); chk("R9 nothing left to claim", d, 0);
    wr(a_ena(0), 0);
  endtask

  task automatic t_tie;
    logic [31:0] d;
    wr(a_prio(7), 4); wr(a_prio(9), 4); wr(a_prio(12), 6);
    wr(a_ena(1), (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 12));
    src_level[6] = 1'b1; src_level[8] = 1'b1; src_level[11] = 1'b1;
    idle(3);
    chk("R5 supervisor context raised", 32'(ctx_irq), 32'b0010);
    rd(a_clm(1), d); chk("R7 highest priority first", d, 12);
    rd(a_clm(1), d); chk("R7 tie goes to lower ID", d, 7);
    rd(a_clm(1), d); chk("R7 remaining source", d, 9);
    rd(a_clm(1), d); chk("R7 drained", d, 0);
    src_level[6] = 1'b0; src_level[8] = 1'b0; src_level[11] = 1'b0;
    wr(a_clm(1), 12); wr(a_clm(1), 7); wr(a_clm(1), 9);
    wr(a_ena(1), 0);
  endtask

  task automatic t_zero_prio;
    logic [31:0] d;
    wr(a_prio(20), 0);
    wr(a_ena(2), 32'h1 << 20);
    src_level[19] = 1'b1;
    idle(3);
    chk("R6 zero priority raises nothing", 32'(ctx_irq), 0);
    rd(a_clm(2), d); chk("R6 zero priority not claimable", d, 0);
    src_level[19] = 1'b0;
  endtask

  task automatic t_contexts;
    logic [31:0] d;
    wr(a_prio(3), 1);
    wr(a_ena(3), 32'h1 << 3);
    src_level[2] = 1'b1;
    idle(3);
    chk("R11 only enabling context raised", 32'(ctx_irq), 32'b1000);
    rd(a_clm(0), d); chk("R11 other context claims nothing", d, 0);
    rd(a_clm(3), d); chk("R11 enabling context claims", d, 3);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_level = '0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_regs;
    t_threshold_and_claim;
    t_tie;
    t_zero_prio;
    t_contexts;
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule